// File: doc/BRIEF.md
# Time-Slotted ADC Input Sequencer

This block drives the input multiplexer of a single shared ADC through a programmable number of time slots. Each slot has two 4-bit signal selections, a regular one and an alternate one. For each slot the block drives the selection onto the multiplexer and pulses a conversion start. It then waits a programmed number of slow-clock (32 kHz) periods. At the end it writes the filter result into a result RAM. The RAM address is fixed by the selected signal code, not by the slot number, so software finds each signal at a stable address whatever slot order it programs.

A sequence starts on the first slow-clock tick that arrives while the block is idle and the slot count is non-zero. The configuration is captured at that tick and holds for the whole sequence. A one-shot alternate request makes every slot of the next sequence use its alternate selection. This lets non-mains signals such as temperature or battery voltage be sampled now and then in place of their regular channels. `slow_tick_i` is a one-clock enable that marks each rising edge of the slow clock.

Top module: `adc_slot_seq`

## Requirements
- R1: A sequence runs exactly `slot_count_i` slots, numbered from 0 upward. A count above 10 runs 10 slots. A count of 0 starts no conversion, drives `mux_sel_o` to 0 and writes nothing.
- R2: When the alternate request is not active, slot k drives `reg_sel_i[4k+3:4k]` on `mux_sel_o` from its conversion start until its end tick.
- R3: The selections of slots at or beyond the slot count have no effect. They produce no conversion start and no RAM write.
- R4: Every slot begins on a slow tick. `conv_start_o` is high for exactly one clock, in the clock cycle right after the clock edge that samples that tick.
- R5: A slot lasts `fir_len_i`+1 slow ticks for codes 0, 1 and 2. Code 3 behaves as code 2. Consecutive conversion starts are therefore 1, 2 or 3 tick periods apart.
- R6: A slot's result is written in the clock cycle after the edge that samples its end tick. Selection codes 0 to 6 map to RAM addresses 0 to 6. Code 10 maps to address 7 and code 11 to address 8.
- R7: The written word is `conv_data_i`, sampled at the end-tick edge, shifted left by 8. Its low 8 bits are zero.
- R8: A one-clock pulse on `alt_req_i` sets `alt_pend_o`. A sequence that starts while `alt_pend_o` is 1 uses `alt_sel_i[4k+3:4k]` for every slot k. `alt_pend_o` clears when that sequence completes, and the next sequence uses the regular selections again.
- R9: `seq_done_o` is high for one clock. It rises one clock after the last slot's write cycle, which is two clocks after the edge that samples the final end tick.
- R10: Changes to the slot count, the selections or the filter length made during a running sequence do not affect that sequence.
- R11: A slot whose code is 7, 8, 9 or 12 to 15 still takes its full slot time but writes nothing to the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-clock pulse marking each rising slow-clock edge |
| slot_count_i | input | 4 | Number of active slots per sequence |
| fir_len_i | input | 2 | Slot length code (0 to 2 gives 1 to 3 ticks) |
| reg_sel_i | input | 40 | Regular selections, 4 bits per slot, slot k at [4k+3:4k] |
| alt_sel_i | input | 40 | Alternate selections, same layout |
| alt_req_i | input | 1 | Pulse that requests one alternate sequence |
| alt_pend_o | output | 1 | Alternate request pending |
| mux_sel_o | output | 4 | Multiplexer selection of the current slot |
| conv_start_o | output | 1 | Conversion start strobe |
| conv_data_i | input | 24 | Filter result of the current conversion |
| ram_we_o | output | 1 | Result RAM write enable |
| ram_addr_o | output | 4 | Result RAM address |
| ram_wdata_o | output | 32 | Result RAM write data |
| seq_done_o | output | 1 | Sequence completion strobe |

## Verification
The slots are given scrambled codes so that every address check tells signal-keyed addressing apart from slot-keyed addressing. A design that used the slot number would write the wrong words. Unused slots and invalid codes are filled with codes that would otherwise write, so a count that ran one slot too far or a missing validity check shows up as extra RAM writes. The spacing of the starts is measured for every filter-length code, including code 3, which catches off-by-one slot timers. Mid-sequence edits to the count, the selections and the length, together with a second sequence after an alternate one, expose designs that read live configuration or never clear the alternate request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned N_CHAN = 7;
  localparam logic [SEL_W-1:0] CODE_X0 = 4'hA;
  localparam logic [SEL_W-1:0] CODE_X1 = 4'hB;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] addr;
  } ram_slot_t;

  // Result address is keyed by signal code, not slot index.
  function automatic ram_slot_t map_addr(input logic [SEL_W-1:0] code);
    ram_slot_t r;
    r.valid = 1'b0;
    r.addr  = '0;
    if (code < SEL_W'(N_CHAN)) begin
      r.valid = 1'b1;
      r.addr  = ADDR_W'(code);
    end else if (code == CODE_X0) begin
      r.valid = 1'b1;
      r.addr  = ADDR_W'(N_CHAN);
    end else if (code == CODE_X1) begin
      r.valid = 1'b1;
      r.addr  = ADDR_W'(N_CHAN + 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/seq_cfg_latch.sv
module seq_cfg_latch #(
  parameter int unsigned SLOTS_MAX = 10,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                load_i,
  input  logic                                use_alt_i,
  input  logic [CNT_W-1:0]                    count_i,
  input  logic [1:0]                          fir_len_i,
  input  logic [SLOTS_MAX*SEL_W-1:0]          reg_sel_i,
  input  logic [SLOTS_MAX*SEL_W-1:0]          alt_sel_i,
  output logic [CNT_W-1:0]                    count_o,
  output logic [1:0]                          len_o,
  output logic [SLOTS_MAX-1:0][SEL_W-1:0]     sel_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(SLOTS_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      len_o   <= '0;
    end else if (load_i) begin
      count_o <= (count_i > MAX_CNT) ? MAX_CNT : count_i;
      len_o   <= (fir_len_i == 2'd3) ? 2'd2 : fir_len_i;
    end
  end

  // Only the effective selection is stored per slot.
  for (genvar g = 0; g < SLOTS_MAX; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_o[g] <= '0;
      end else if (load_i) begin
        sel_o[g] <= use_alt_i ? alt_sel_i[g*SEL_W +: SEL_W]
                              : reg_sel_i[g*SEL_W +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/slot_timer.sv
module slot_timer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic [1:0] len_i,
  output logic       end_o
);
  logic [1:0] cnt_q;

  assign end_o = tick_i && (cnt_q == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || end_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/result_writer.sv
module result_writer
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SHIFT  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    end_i,
  input  logic [SEL_W-1:0]        code_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    we_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [DATA_W+SHIFT-1:0] data_o
);
  ram_slot_t slot_w;

  assign slot_w = map_addr(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= end_i && slot_w.valid;
      if (end_i && slot_w.valid) begin
        addr_o <= slot_w.addr;
        data_o <= {data_i, {SHIFT{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/adc_slot_seq.sv
module adc_slot_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned SLOTS_MAX = 10,
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned SHIFT     = 8,
  localparam int unsigned CNT_W    = $clog2(SLOTS_MAX + 1),
  localparam int unsigned RAM_W    = DATA_W + SHIFT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       slow_tick_i,
  input  logic [CNT_W-1:0]           slot_count_i,
  input  logic [1:0]                 fir_len_i,
  input  logic [SLOTS_MAX*SEL_W-1:0] reg_sel_i,
  input  logic [SLOTS_MAX*SEL_W-1:0] alt_sel_i,
  input  logic                       alt_req_i,
  output logic                       alt_pend_o,
  output logic [SEL_W-1:0]           mux_sel_o,
  output logic                       conv_start_o,
  input  logic [DATA_W-1:0]          conv_data_i,
  output logic                       ram_we_o,
  output logic [ADDR_W-1:0]          ram_addr_o,
  output logic [RAM_W-1:0]           ram_wdata_o,
  output logic                       seq_done_o
);
  seq_state_e                     state_q;
  logic [CNT_W-1:0]               slot_q;
  logic [CNT_W-1:0]               cnt_l;
  logic [1:0]                     len_l;
  logic [SLOTS_MAX-1:0][SEL_W-1:0] sel_l;
  logic                           alt_act_q;
  logic                           fin_q;
  logic                           start_q;
  logic                           done_q;
  logic                           pend_q;
  logic                           start_seq;
  logic                           run_tick;
  logic                           slot_end;
  logic                           last_slot;
  logic [SEL_W-1:0]               cur_sel;

  assign start_seq = (state_q == ST_IDLE) && slow_tick_i && (slot_count_i != '0);
  assign run_tick  = (state_q == ST_RUN) && slow_tick_i;
  assign last_slot = (slot_q == cnt_l - CNT_W'(1));
  assign cur_sel   = sel_l[slot_q];

  seq_cfg_latch #(
    .SLOTS_MAX (SLOTS_MAX),
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_seq),
    .use_alt_i (pend_q),
    .count_i   (slot_count_i),
    .fir_len_i (fir_len_i),
    .reg_sel_i (reg_sel_i),
    .alt_sel_i (alt_sel_i),
    .count_o   (cnt_l),
    .len_o     (len_l),
    .sel_o     (sel_l)
  );

  slot_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (start_seq),
    .tick_i    (run_tick),
    .len_i     (len_l),
    .end_o     (slot_end)
  );

  result_writer #(
    .DATA_W (DATA_W),
    .SHIFT  (SHIFT)
  ) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .end_i  (slot_end),
    .code_i (cur_sel),
    .data_i (conv_data_i),
    .we_o   (ram_we_o),
    .addr_o (ram_addr_o),
    .data_o (ram_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      slot_q    <= '0;
      alt_act_q <= 1'b0;
      start_q   <= 1'b0;
      fin_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      start_q <= start_seq || (slot_end && !last_slot);
      fin_q   <= slot_end && last_slot;
      done_q  <= fin_q;
      if (start_seq) begin
        state_q   <= ST_RUN;
        slot_q    <= '0;
        alt_act_q <= pend_q;
      end else if (slot_end) begin
        if (last_slot) state_q <= ST_IDLE;
        else           slot_q  <= slot_q + CNT_W'(1);
      end
    end
  end

  // Request wins over the self-clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pend_q <= 1'b0;
    else if (alt_req_i)           pend_q <= 1'b1;
    else if (fin_q && alt_act_q)  pend_q <= 1'b0;
  end

  assign alt_pend_o   = pend_q;
  assign conv_start_o = start_q;
  assign seq_done_o   = done_q;
  assign mux_sel_o    = (state_q == ST_RUN) ? cur_sel : '0;
endmodule

// File: rtl/adc_slot_seq_chk.sv
module adc_slot_seq_chk #(
  parameter int unsigned SHIFT  = 8,
  parameter int unsigned RAM_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slow_tick_i,
  input logic             conv_start_o,
  input logic             ram_we_o,
  input logic [3:0]       ram_addr_o,
  input logic [RAM_W-1:0] ram_wdata_o,
  input logic             seq_done_o
);
  a_r4_start_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(slow_tick_i));
  a_r4_start_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  a_r6_we_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> $past(slow_tick_i));
  a_r6_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o <= 4'd8));
  a_r7_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_wdata_o[SHIFT-1:0] == '0));
  a_r9_done_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |=> !seq_done_o);
  a_r9_done_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> !conv_start_o);
endmodule

bind adc_slot_seq adc_slot_seq_chk #(
  .SHIFT (SHIFT),
  .RAM_W (RAM_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slow_tick_i  (slow_tick_i),
  .conv_start_o (conv_start_o),
  .ram_we_o     (ram_we_o),
  .ram_addr_o   (ram_addr_o),
  .ram_wdata_o  (ram_wdata_o),
  .seq_done_o   (seq_done_o)
);

// File: tb/adc_slot_seq_tb.sv
module adc_slot_seq_tb;
  localparam int TICK_P = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_tick = 1'b0;
  logic [3:0]  slot_count = '0;
  logic [1:0]  fir_len = '0;
  logic [39:0] reg_sel = '0;
  logic [39:0] alt_sel = '0;
  logic        alt_req = 1'b0;
  logic        alt_pend;
  logic [3:0]  mux_sel;
  logic        conv_start;
  logic [23:0] conv_data;
  logic        ram_we;
  logic [3:0]  ram_addr;
  logic [31:0] ram_wdata;
  logic        seq_done;

  logic [7:0]  salt = 8'h00;
  assign conv_data = {8'hC3, salt, 4'h0, mux_sel};

  adc_slot_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .slow_tick_i  (slow_tick),
    .slot_count_i (slot_count),
    .fir_len_i    (fir_len),
    .reg_sel_i    (reg_sel),
    .alt_sel_i    (alt_sel),
    .alt_req_i    (alt_req),
    .alt_pend_o   (alt_pend),
    .mux_sel_o    (mux_sel),
    .conv_start_o (conv_start),
    .conv_data_i  (conv_data),
    .ram_we_o     (ram_we),
    .ram_addr_o   (ram_addr),
    .ram_wdata_o  (ram_wdata),
    .seq_done_o   (seq_done)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_tick = -100;
  bit tick_en = 1'b0;
  int tdiv = 0;

  int n_start, n_wr, n_done, done_cyc;
  int start_cyc [16];
  logic [3:0]  wr_addr [16];
  logic [31:0] wr_data [16];
  logic [3:0]  exp_codes [10];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (slow_tick) last_tick = cyc;
  end

  always @(negedge clk) begin
    if (!tick_en) begin
      tdiv = 0;
      slow_tick = 1'b0;
    end else begin
      slow_tick = (tdiv == TICK_P - 1);
      tdiv = (tdiv == TICK_P - 1) ? 0 : tdiv + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (conv_start) begin
        chk(last_tick == cyc, "R4 start cycle after tick", cyc - last_tick, 0);
        if (n_start < 16) start_cyc[n_start] = cyc;
        n_start++;
      end
      if (ram_we) begin
        chk(last_tick == cyc, "R6 write cycle after tick", cyc - last_tick, 0);
        if (n_wr < 16) begin
          wr_addr[n_wr] = ram_addr;
          wr_data[n_wr] = ram_wdata;
        end
        n_wr++;
      end
      if (seq_done) begin
        n_done++;
        done_cyc = cyc;
      end
    end
  end

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic logic [4:0] exp_map(input logic [3:0] c);
    if (c <= 4'd6) return {1'b1, c};
    if (c == 4'hA) return {1'b1, 4'd7};
    if (c == 4'hB) return {1'b1, 4'd8};
    return 5'd0;
  endfunction

  task automatic clear_log();
    n_start = 0; n_wr = 0; n_done = 0; done_cyc = 0;
  endtask

  task automatic set_reg(input int k, input logic [3:0] c);
    reg_sel[k*4 +: 4] = c;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (n_done == 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    tick_en = 1'b0;
    chk(n_done == 1, {req, " sequence completed"}, n_done, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic verify(input string req, input int cnt, input int len_eff);
    int e;
    logic [4:0] m;
    e = 0;
    chk(n_start == cnt, {req, " R1 start count"}, n_start, cnt);
    for (int i = 0; i < cnt; i++) begin
      m = exp_map(exp_codes[i]);
      if (m[4]) begin
        if (e < n_wr && e < 16) begin
          chk(wr_addr[e] == m[3:0], {req, " R6 address"}, wr_addr[e], m[3:0]);
          chk(wr_data[e] == {8'hC3, salt, 4'h0, exp_codes[i], 8'h00},
              {req, " R7 data"}, wr_data[e], {8'hC3, salt, 4'h0, exp_codes[i], 8'h00});
        end
        e++;
      end
    end
    chk(n_wr == e, {req, " R3 R11 write count"}, n_wr, e);
    for (int i = 1; i < cnt && i < 16 && i < n_start; i++)
      chk(start_cyc[i] - start_cyc[i-1] == (len_eff + 1) * TICK_P, {req, " R5 slot spacing"},
          start_cyc[i] - start_cyc[i-1], (len_eff + 1) * TICK_P);
    if (n_start >= cnt && cnt > 0)
      chk(done_cyc == start_cyc[cnt-1] + (len_eff + 1) * TICK_P + 1, {req, " R9 done timing"},
          done_cyc, start_cyc[cnt-1] + (len_eff + 1) * TICK_P + 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!conv_start && !ram_we && !seq_done && mux_sel == 0 && !alt_pend,
        "reset outputs idle", {conv_start, ram_we, seq_done, alt_pend, mux_sel}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_seven_regular();
    logic [3:0] c;
    clear_log(); salt = 8'h11;
    slot_count = 4'd7; fir_len = 2'd0;
    for (int k = 0; k < 10; k++) begin
      c = 4'((k * 3) % 7);
      set_reg(k, c);
      exp_codes[k] = c;
    end
    tick_en = 1'b1;
    while (n_start == 0) @(negedge clk);
    chk(mux_sel == exp_codes[0], "R2 slot0 selection on mux", mux_sel, exp_codes[0]);
    wait_done("seven");
    verify("seven R2", 7, 0);
  endtask

  task automatic t_six_len2();
    clear_log(); salt = 8'h22;
    slot_count = 4'd6; fir_len = 2'd2;
    for (int k = 0; k < 6; k++) begin
      set_reg(k, 4'(5 - k));
      exp_codes[k] = 4'(5 - k);
    end
    set_reg(6, 4'd6); set_reg(7, 4'd0); set_reg(8, 4'hA); set_reg(9, 4'hB);
    tick_en = 1'b1;
    wait_done("six");
    verify("six R3", 6, 2);
  endtask

  task automatic t_len1();
    clear_log(); salt = 8'h33;
    slot_count = 4'd3; fir_len = 2'd1;
    for (int k = 0; k < 3; k++) begin
      set_reg(k, 4'(k + 2));
      exp_codes[k] = 4'(k + 2);
    end
    tick_en = 1'b1;
    wait_done("len1");
    verify("len1 R5", 3, 1);
  endtask

  task automatic t_alt();
    clear_log(); salt = 8'h44;
    slot_count = 4'd7; fir_len = 2'd0;
    for (int k = 0; k < 10; k++) begin
      set_reg(k, 4'(k % 7));
      alt_sel[k*4 +: 4] = 4'(k % 7);
    end
    alt_sel[3:0] = 4'hA;
    alt_sel[11:8] = 4'hB;
    @(negedge clk) alt_req = 1'b1;
    @(negedge clk) alt_req = 1'b0;
    chk(alt_pend == 1'b1, "R8 request sets pending", alt_pend, 1);
    for (int k = 0; k < 7; k++) exp_codes[k] = alt_sel[k*4 +: 4];
    tick_en = 1'b1;
    wait_done("alt");
    verify("alt R8", 7, 0);
    chk(alt_pend == 1'b0, "R8 pending cleared after sequence", alt_pend, 0);
    clear_log(); salt = 8'h45;
    for (int k = 0; k < 7; k++) exp_codes[k] = reg_sel[k*4 +: 4];
    tick_en = 1'b1;
    wait_done("alt-next");
    verify("after-alt R8", 7, 0);
  endtask

  task automatic t_latch();
    clear_log(); salt = 8'h55;
    slot_count = 4'd7; fir_len = 2'd0;
    for (int k = 0; k < 7; k++) begin
      set_reg(k, 4'(6 - k));
      exp_codes[k] = 4'(6 - k);
    end
    tick_en = 1'b1;
    while (n_start == 0) @(negedge clk);
    set_reg(5, 4'hB);
    slot_count = 4'd3;
    fir_len = 2'd2;
    wait_done("latch");
    verify("latch R10", 7, 0);
  endtask

  task automatic t_invalid_clamp();
    logic [3:0] cs [10];
    cs = '{4'd0, 4'd7, 4'd1, 4'd8, 4'd2, 4'd9, 4'd3, 4'hC, 4'hA, 4'hF};
    clear_log(); salt = 8'h66;
    slot_count = 4'd15; fir_len = 2'd3;
    for (int k = 0; k < 10; k++) begin
      set_reg(k, cs[k]);
      exp_codes[k] = cs[k];
    end
    tick_en = 1'b1;
    wait_done("clamp");
    verify("clamp R1 R11", 10, 2);
  endtask

  task automatic t_zero();
    clear_log();
    slot_count = 4'd0;
    tick_en = 1'b1;
    repeat (60) @(negedge clk);
    tick_en = 1'b0;
    chk(n_start == 0 && n_wr == 0, "R1 zero count idle", n_start + n_wr, 0);
    chk(mux_sel == 4'd0, "R1 zero count mux", mux_sel, 0);
  endtask

  initial begin
    t_reset();
    t_seven_regular();
    t_six_len2();
    t_len1();
    t_alt();
    t_latch();
    t_invalid_clamp();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule